// File: doc/BRIEF.md
# Real-time clock host register port with update sequencer

This block is the host side of a real-time clock. The host reaches a 128-byte register store through two addresses. A write to address 0 selects a byte index. Address 1 then reads or writes the selected byte. Four bytes have their own rules:
- the status byte (index 10) carries the update-in-progress flag and the divider-select field;
- the control byte (index 11) carries the set-mode bit and the interrupt enables;
- the flag byte (index 12) is cleared when it is read;
- index 13 is read-only.

The calendar arithmetic sits outside the block. An external one-second tick starts an update. If the divider field allows it, the block pulses `inc_o` so that the external calendar advances, and it raises the update-in-progress flag. After `UPD_DELAY` clock cycles it closes the update:
- it copies the seven calendar bytes from `time_i` into the store;
- it compares the three alarm bytes against the current time;
- it sets the update-ended flag;
- it drives a level interrupt, which stays high until the flag byte is read.

Set mode stops the update flag from rising and stops the copy, so the host can load the time bytes freely. A separate synchronous soft reset clears the enables and the flags.

Top module: `rtc_regport`

## Requirements
- R1: A write to address 0 stores `wdata_i[6:0]` as the index, so index values 0x80 and above wrap onto 0x00–0x7F. A read of address 0 returns 0xFF.
- R2: A write to address 1 at any ordinary index (anything other than 10–13) stores the byte unchanged, and a read of that index returns it.
- R3: Bit 7 of index 10 (the update-in-progress flag) cannot be written by the host. A host write replaces only bits 6:0.
- R4: A write to index 11 with bit 7 (set mode) high clears the update-in-progress flag and stores bit 4 (update-ended interrupt enable) as 0.
- R5: Host writes to index 12 and index 13 have no effect.
- R6: A read of index 12 returns its value, clears it to 0x00 on the same clock edge, and drops `irq_o`.
- R7: A tick is ignored unless bits 6:4 of index 10 equal 3'b010. An ignored tick produces no `inc_o`, no update-in-progress flag and no flag change.
- R8: An accepted tick pulses `inc_o` combinationally in the tick cycle and sets the update-in-progress flag at that edge. `UPD_DELAY` edges later the update ends: the `time_i` bytes are stored at indices 0, 2, 4, 6, 7, 8 and 9 (seconds, minutes, hours, weekday, day, month, year); bit 4 (update-ended) of index 12 is set; the update-in-progress flag is cleared.
- R9: While set mode is active, an accepted tick still pulses `inc_o` and still sets the update-ended flag, but the update-in-progress flag stays 0 and the time bytes keep the values the host wrote.
- R10: When the update ends with bit 5 (alarm enable) of index 11 set, the alarm bytes at indices 1, 3 and 5 are compared against the seconds, minutes and hours of `time_i`. A byte matches if its top two bits are both 1 or if it equals the time byte. A full match ORs 0xA0 into index 12 and raises `irq_o`; any mismatch does neither.
- R11: When the update ends with bit 4 of index 11 set, bit 7 of index 12 is set and `irq_o` rises.
- R12: After `rst_ni` the four special bytes read 0x26, 0x02, 0x00 and 0x80 (indices 10 to 13), and `irq_o` is 0.
- R13: A `soft_rst_i` pulse clears bits 6, 5 and 3 of index 11 and bits 7 to 4 of index 12, and drops `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous partial reset of the enables, the flags and the interrupt |
| req_i | input | 1 | Host access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 1 | 0 = index port, 1 = data port |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data, valid combinationally in the access cycle |
| tick_i | input | 1 | One-second tick strobe |
| time_i | input | 56 | Calendar bytes from the external counter, seconds in the low byte |
| inc_o | output | 1 | Pulse asking the external calendar to advance |
| irq_o | output | 1 | Level interrupt |

## Verification
- `rdata_o` is combinational. Each read is sampled in its own access cycle, and a side effect of a read (such as clearing the flag byte) is checked on the next access.
- `inc_o` is due in the same cycle as the tick.
- The update-in-progress flag is visible from the first edge after the tick. The bench reads it on the very next access, inside the delay window.
- The copied time, the flags and `irq_o` settle on the `UPD_DELAY`-th edge after the tick. The bench waits two extra edges before it reads any of them.
- `soft_rst_i` takes effect at the edge where it is sampled, so `irq_o` is checked just after that edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // index map: update logic decodes these positions
  localparam int IX_SEC_ALM = 1;
  localparam int IX_MIN_ALM = 3;
  localparam int IX_HR_ALM  = 5;
  localparam int IX_STAT    = 10;
  localparam int IX_CTRL    = 11;
  localparam int IX_FLAG    = 12;
  localparam int IX_VALID   = 13;

  // status / control / flag bit positions
  localparam int B_UIP  = 7;
  localparam int B_SET  = 7;
  localparam int B_PIE  = 6;
  localparam int B_AIE  = 5;
  localparam int B_UIE  = 4;
  localparam int B_SQWE = 3;
  localparam int B_IRQF = 7;
  localparam int B_PF   = 6;
  localparam int B_AF   = 5;
  localparam int B_UF   = 4;

  localparam logic [7:0] STAT_RST  = 8'h26;
  localparam logic [7:0] CTRL_RST  = 8'h02;
  localparam logic [7:0] FLAG_RST  = 8'h00;
  localparam logic [7:0] VALID_RST = 8'h80;
  localparam logic [2:0] DIV_RUN   = 3'b010;
  localparam logic [1:0] ALM_ANY   = 2'b11;

  localparam int NUM_TIME = 7;
endpackage

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq #(
  parameter int unsigned DELAY = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic div_ok_i,
  input  logic set_mode_i,
  output logic inc_o,
  output logic uip_set_o,
  output logic upd_end_o
);
  localparam int unsigned CNT_W = (DELAY < 2) ? 1 : $clog2(DELAY);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign inc_o     = tick_i && div_ok_i && !busy_q;
  assign uip_set_o = inc_o && !set_mode_i;
  assign upd_end_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (inc_o) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(DELAY - 1);
    end else if (upd_end_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp import rtc_pkg::*; #(
  parameter int unsigned NUM = 3
) (
  input  logic [NUM*8-1:0] alarm_i,
  input  logic [NUM*8-1:0] now_i,
  output logic             match_o
);
  logic [NUM-1:0] hit;

  for (genvar g = 0; g < NUM; g++) begin : g_byte
    logic [7:0] a, n;
    assign a      = alarm_i[g*8 +: 8];
    assign n      = now_i[g*8 +: 8];
    assign hit[g] = (a[7:6] == ALM_ANY) || (a == n);
  end

  assign match_o = &hit;
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport import rtc_pkg::*; #(
  parameter int unsigned UPD_DELAY = 8,
  parameter int unsigned IDX_W     = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  soft_rst_i,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic                  addr_i,
  input  logic [7:0]            wdata_i,
  output logic [7:0]            rdata_o,
  input  logic                  tick_i,
  input  logic [NUM_TIME*8-1:0] time_i,
  output logic                  inc_o,
  output logic                  irq_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] I_STAT  = IDX_W'(IX_STAT);
  localparam logic [IDX_W-1:0] I_CTRL  = IDX_W'(IX_CTRL);
  localparam logic [IDX_W-1:0] I_FLAG  = IDX_W'(IX_FLAG);
  localparam logic [IDX_W-1:0] I_VALID = IDX_W'(IX_VALID);

  // time byte k -> store index: sec/min/hr interleaved with alarms, rest packed
  function automatic logic [IDX_W-1:0] time_idx(input int k);
    return (k < 3) ? IDX_W'(2 * k) : IDX_W'(k + 3);
  endfunction

  logic [7:0]       store_q [DEPTH];
  logic [IDX_W-1:0] idx_q;
  logic             irq_q;

  logic [7:0] reg_a, reg_b, reg_c, reg_d;
  assign reg_a = store_q[I_STAT];
  assign reg_b = store_q[I_CTRL];
  assign reg_c = store_q[I_FLAG];
  assign reg_d = store_q[I_VALID];

  logic wr_idx, wr_dat, rd_dat, rd_c, wr_a, wr_b, wr_d, set_wr;
  assign wr_idx = req_i && we_i && !addr_i;
  assign wr_dat = req_i && we_i && addr_i;
  assign rd_dat = req_i && !we_i && addr_i;
  assign rd_c   = rd_dat && (idx_q == I_FLAG);
  assign wr_a   = wr_dat && (idx_q == I_STAT);
  assign wr_b   = wr_dat && (idx_q == I_CTRL);
  assign wr_d   = wr_dat && (idx_q == I_VALID);
  assign set_wr = wr_b && wdata_i[B_SET];

  logic seq_inc, seq_uip_set, seq_end, alarm_hit;

  rtc_upd_seq #(.DELAY(UPD_DELAY)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .div_ok_i   (reg_a[6:4] == DIV_RUN),
    .set_mode_i (reg_b[B_SET]),
    .inc_o      (seq_inc),
    .uip_set_o  (seq_uip_set),
    .upd_end_o  (seq_end)
  );

  rtc_alarm_cmp #(.NUM(3)) u_alarm (
    .alarm_i ({store_q[IX_HR_ALM], store_q[IX_MIN_ALM], store_q[IX_SEC_ALM]}),
    .now_i   (time_i[23:0]),
    .match_o (alarm_hit)
  );

  logic       alm_fire, ue_fire;
  logic [7:0] new_flags, c_next;
  assign alm_fire  = seq_end && reg_b[B_AIE] && alarm_hit;
  assign ue_fire   = seq_end && reg_b[B_UIE];
  assign new_flags = {alm_fire || ue_fire, 1'b0, alm_fire, seq_end, 4'h0};
  assign c_next    = (rd_c ? 8'h00 : reg_c) | new_flags;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) store_q[i] <= 8'h00;
      store_q[I_STAT]  <= STAT_RST;
      store_q[I_CTRL]  <= CTRL_RST;
      store_q[I_FLAG]  <= FLAG_RST;
      store_q[I_VALID] <= VALID_RST;
      idx_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_idx) idx_q <= wdata_i[IDX_W-1:0];
      if (wr_dat) begin
        unique case (idx_q)
          I_STAT:          store_q[I_STAT] <= {reg_a[B_UIP], wdata_i[6:0]};
          I_CTRL:          store_q[I_CTRL] <= set_wr ? (wdata_i & ~(8'h1 << B_UIE)) : wdata_i;
          I_FLAG, I_VALID: ;
          default:         store_q[idx_q] <= wdata_i;
        endcase
      end
      if (seq_uip_set && !set_wr) store_q[I_STAT][B_UIP] <= 1'b1;
      if (seq_end) begin
        if (!reg_b[B_SET])
          for (int k = 0; k < NUM_TIME; k++) store_q[time_idx(k)] <= time_i[k*8 +: 8];
        store_q[I_STAT][B_UIP] <= 1'b0;
      end
      if (set_wr) store_q[I_STAT][B_UIP] <= 1'b0;
      store_q[I_FLAG] <= c_next;
      if (rd_c) irq_q <= 1'b0;
      if (alm_fire || ue_fire) irq_q <= 1'b1;
      // soft reset acts on the current control value and wins over same-cycle events
      if (soft_rst_i) begin
        store_q[I_CTRL] <= reg_b & ~((8'h1 << B_PIE) | (8'h1 << B_AIE) | (8'h1 << B_SQWE));
        store_q[I_FLAG] <= reg_c & 8'h0F;
        irq_q <= 1'b0;
      end
    end
  end

  assign rdata_o = addr_i ? store_q[idx_q] : 8'hFF;
  assign inc_o   = seq_inc;
  assign irq_o   = irq_q;
endmodule

// File: rtl/rtc_regport_chk.sv
module rtc_regport_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       soft_rst_i,
  input logic       inc_o,
  input logic       irq_o,
  input logic       seq_uip_set,
  input logic       seq_end,
  input logic       rd_c,
  input logic       wr_a,
  input logic       wr_b,
  input logic       wr_d,
  input logic [7:0] wdata_i,
  input logic [7:0] reg_a,
  input logic [7:0] reg_b,
  input logic [7:0] reg_d
);
  // R7
  inc_needs_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_o |-> (reg_a[6:4] == 3'b010));

  // R8
  uip_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_end |=> !reg_a[7]);

  // R3
  uip_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_a && !seq_uip_set && !seq_end) |=> (reg_a[7] == $past(reg_a[7])));

  // R4
  set_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_b && wdata_i[7] && !soft_rst_i) |=> (!reg_a[7] && !reg_b[4]));

  // R5
  valid_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_d |=> $stable(reg_d));

  // R6
  flag_read_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_c && !seq_end) |=> !irq_o);

  // R13
  soft_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !irq_o);

  // R11
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(seq_end));
endmodule

bind rtc_regport rtc_regport_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .soft_rst_i  (soft_rst_i),
  .inc_o       (inc_o),
  .irq_o       (irq_o),
  .seq_uip_set (seq_uip_set),
  .seq_end     (seq_end),
  .rd_c        (rd_c),
  .wr_a        (wr_a),
  .wr_b        (wr_b),
  .wr_d        (wr_d),
  .wdata_i     (wdata_i),
  .reg_a       (reg_a),
  .reg_b       (reg_b),
  .reg_d       (reg_d)
);

// File: tb/rtc_regport_test.sv
module rtc_regport_test;
  localparam int unsigned DLY = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        req = 1'b0, we = 1'b0, addr = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        tick = 1'b0;
  logic [55:0] tm = '0;
  logic        inc, irq;

  int total = 0, bad = 0, cycles = 0;

  always #5 clk = ~clk;

  rtc_regport #(.UPD_DELAY(DLY)) uut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .tick_i(tick), .time_i(tm), .inc_o(inc), .irq_o(irq)
  );

  // {index written, data, index read, expected}
  localparam logic [31:0] VEC [0:6] = '{
    32'h0E_5A_0E_5A,  // R2
    32'h7F_C3_7F_C3,  // R2
    32'h8E_11_0E_11,  // R1 index wraps
    32'h0C_FF_0C_00,  // R5 flag byte
    32'h0D_00_0D_80,  // R5 read-only byte
    32'h0A_A5_0A_25,  // R3 bit 7 not writable
    32'h01_30_01_30   // R2 alarm byte
  };
  localparam int VREQ [0:6] = '{2, 2, 1, 5, 5, 3, 2};

  task automatic check(input int r, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic bus(input logic a, input logic w, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1 q = rdata;
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] i, input logic [7:0] v);
    logic [7:0] q;
    bus(1'b0, 1'b1, i, q);
    bus(1'b1, 1'b1, v, q);
  endtask

  task automatic get_reg(input logic [7:0] i, output logic [7:0] v);
    logic [7:0] q;
    bus(1'b0, 1'b1, i, q);
    bus(1'b1, 1'b0, 8'h00, v);
  endtask

  task automatic pulse_tick(output logic inc_seen);
    @(negedge clk);
    tick = 1'b1;
    #1 inc_seen = inc;
    @(posedge clk);
    #1 tick = 1'b0;
  endtask

  task automatic wait_update();
    repeat (DLY + 2) @(posedge clk);
    #1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= 100000) begin
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] v;
    logic       s;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R12 reset state
    get_reg(8'd10, v); check(12, v, 8'h26);
    get_reg(8'd11, v); check(12, v, 8'h02);
    get_reg(8'd12, v); check(12, v, 8'h00);
    get_reg(8'd13, v); check(12, v, 8'h80);
    check(12, {7'h0, irq}, 8'h00);

    // R1 even read
    bus(1'b0, 1'b0, 8'h00, v); check(1, v, 8'hFF);

    for (int i = 0; i < 7; i++) begin
      set_reg(VEC[i][31:24], VEC[i][23:16]);
      get_reg(VEC[i][15:8], v);
      check(VREQ[i], v, VEC[i][7:0]);
    end

    // R7 divider stopped: tick ignored
    set_reg(8'd10, 8'h06);
    pulse_tick(s); check(7, {7'h0, s}, 8'h00);
    bus(1'b1, 1'b0, 8'h00, v); check(7, v, 8'h06);
    wait_update();
    get_reg(8'd12, v); check(7, v, 8'h00);

    // R8 normal update
    set_reg(8'd10, 8'h26);
    tm = {8'h24, 8'h12, 8'h31, 8'h03, 8'h23, 8'h59, 8'h58};
    pulse_tick(s); check(8, {7'h0, s}, 8'h01);
    bus(1'b1, 1'b0, 8'h00, v); check(8, v, 8'hA6);
    wait_update();
    bus(1'b1, 1'b0, 8'h00, v); check(8, v, 8'h26);
    get_reg(8'd0, v); check(8, v, 8'h58);
    get_reg(8'd2, v); check(8, v, 8'h59);
    get_reg(8'd9, v); check(8, v, 8'h24);
    get_reg(8'd12, v); check(8, v, 8'h10);
    check(8, {7'h0, irq}, 8'h00);

    // R6 flag byte cleared by the read
    get_reg(8'd12, v); check(6, v, 8'h00);

    // R11 update-ended interrupt
    set_reg(8'd11, 8'h12);
    pulse_tick(s);
    wait_update();
    check(11, {7'h0, irq}, 8'h01);
    get_reg(8'd12, v); check(11, v, 8'h90);
    check(6, {7'h0, irq}, 8'h00);  // R6
    get_reg(8'd12, v); check(6, v, 8'h00);

    // R10 alarm match with a don't-care seconds byte
    set_reg(8'd1, 8'hC0);
    set_reg(8'd3, 8'h59);
    set_reg(8'd5, 8'h23);
    set_reg(8'd11, 8'h22);
    pulse_tick(s);
    wait_update();
    check(10, {7'h0, irq}, 8'h01);
    get_reg(8'd12, v); check(10, v, 8'hB0);
    // R10 mismatch on the hours byte
    set_reg(8'd5, 8'h11);
    pulse_tick(s);
    wait_update();
    check(10, {7'h0, irq}, 8'h00);
    get_reg(8'd12, v); check(10, v, 8'h10);

    // R9 set mode: no UIP, no copy, UF still set
    set_reg(8'd11, 8'h82);
    set_reg(8'd0, 8'h33);
    set_reg(8'd10, 8'h26);
    tm[7:0] = 8'h07;
    pulse_tick(s); check(9, {7'h0, s}, 8'h01);
    bus(1'b1, 1'b0, 8'h00, v); check(9, v, 8'h26);
    wait_update();
    get_reg(8'd0, v); check(9, v, 8'h33);
    get_reg(8'd12, v); check(9, v, 8'h10);

    // R4 entering set mode during an update
    set_reg(8'd11, 8'h12);
    pulse_tick(s);
    bus(1'b1, 1'b1, 8'h92, v);
    get_reg(8'd10, v); check(4, v, 8'h26);
    get_reg(8'd11, v); check(4, v, 8'h82);
    wait_update();
    check(4, {7'h0, irq}, 8'h00);
    set_reg(8'd11, 8'h02);
    get_reg(8'd12, v);

    // R13 soft reset
    set_reg(8'd11, 8'h7A);
    pulse_tick(s);
    wait_update();
    check(13, {7'h0, irq}, 8'h01);
    @(negedge clk); soft_rst = 1'b1;
    @(posedge clk); #1 soft_rst = 1'b0;
    check(13, {7'h0, irq}, 8'h00);
    get_reg(8'd11, v); check(13, v, 8'h12);
    get_reg(8'd12, v); check(13, v, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule